// File: doc/BRIEF.md
# Configurable 64-bit Shift Unit

This block is the shift execution unit of a 64-bit processor. It is purely combinational. It takes an operation code, a data operand, a shift-amount operand, a word-mode flag and an arithmetic flag, and in the same cycle it returns a 64-bit result with a valid flag. It supports three operations, and each runs in a 64-bit mode or a 32-bit word mode:

- a left shift;
- a right shift, either logical or arithmetic;
- a fused operation that sign-extends the low word of the data and then shifts it left.

The amount operand is read through a 7-bit window in 64-bit mode and a 6-bit window in word mode. In 64-bit mode, amounts from 64 to 127 are legal. They drive every result bit to the fill value: zero for a left shift or a logical right shift, and the sign bit for an arithmetic right shift.

A third operand port carries the rotate source that other units of the same slot use. This unit never reads it. Each operation is routed through one shared barrel shifter. A decode stage places the operand, the fill bit and the effective amount, and a merge stage forces the upper word in word mode.

Top module: `shift_unit`

## Requirements
- R1: Operation codes are `op_i`=1 shift left, 2 shift right, 3 sign-extend-word then shift left. For these codes `valid_o` is 1 in the same cycle. Codes 0 and 4 to 7 give `valid_o`=0 and `result_o`=0.
- R2: Shift left in 64-bit mode (`word_mode_i`=0) returns `data_i` shifted left by `amount_i[6:0]`, truncated to 64 bits. Amounts of 64 or more give 0.
- R3: Shift left in word mode (`word_mode_i`=1) shifts `data_i[31:0]` left by `amount_i[5:0]`. The result keeps the low 32 bits, and `result_o[63:32]` is 0.
- R4: Shift right in 64-bit mode with `arith_i`=0 is a logical shift of `data_i` by `amount_i[6:0]` with zero fill. Amounts of 64 or more give 0.
- R5: Shift right in 64-bit mode with `arith_i`=1 treats `data_i` as signed and shifts it right by `amount_i[6:0]`. Amounts of 64 or more give 64 copies of `data_i[63]`.
- R6: Shift right in word mode with `arith_i`=0 shifts `data_i[31:0]` right by `amount_i[5:0]` with zero fill. `result_o[63:32]` is 0.
- R7: Shift right in word mode with `arith_i`=1 arithmetically shifts `data_i[31:0]` by `amount_i[5:0]` into `result_o[31:0]`. Amounts of 32 to 63 give copies of bit 31. Every bit of `result_o[63:32]` equals `data_i[31]`.
- R8: Sign-extend-word then shift left in word mode returns `data_i[31:0]` shifted left by `amount_i[5:0]`, masked to 32 bits. `result_o[63:32]` is 0.
- R9: Sign-extend-word then shift left in 64-bit mode first sign-extends `data_i[31:0]` to 64 bits. It then shifts that value left by `amount_i[6:0]` and truncates it to 64 bits.
- R10: The following inputs have no effect on the result:
  - `rot_i`;
  - `amount_i` bits above the mode's window (bits 63:7, and bit 6 in word mode);
  - `arith_i` for the two left-shift operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (1 shl, 2 shr, 3 sign-extend-word shl) |
| word_mode_i | input | 1 | 1 selects 32-bit word mode |
| arith_i | input | 1 | 1 selects arithmetic (signed) right shift |
| data_i | input | 64 | Data operand |
| amount_i | input | 64 | Shift-amount operand; only the low bits are used |
| rot_i | input | 64 | Rotate source operand, ignored |
| result_o | output | 64 | Shift result |
| valid_o | output | 1 | Result valid for a supported operation code |

## Verification
The hardest corner is where the mode window and the fill source interact. Examples are an arithmetic word shift by 32 to 63 positions, or a 64-bit sign-extend shift by 32 or more, where the only surviving bits come from the extended sign. The bench reaches these cases with a near-exhaustive sweep over every operation code, mode and arithmetic flag, crossed with data values chosen to have bit 31 and bit 63 in all combinations and with amounts on every window boundary (0, 1, 31, 32, 33, 63, 64, 65, 127). It then repeats selected vectors with the ignored amount bits and the rotate operand scrambled, and expects the result to be unchanged.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

  localparam int OP_W = 3;

  // Supported operation codes; every other code is unsupported.
  typedef enum logic [OP_W-1:0] {
    SOP_NONE    = 3'd0,
    SOP_SHL     = 3'd1,
    SOP_SHR     = 3'd2,
    SOP_SXW_SHL = 3'd3
  } shift_op_e;

  // Control word handed from decode to the barrel and merge stages.
  typedef struct packed {
    logic valid;
    logic dir_right;
    logic word;
    logic fill;
  } shift_ctl_t;

endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_unit_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AMTW = $clog2(XLEN) + 1
) (
  input  logic [OP_W-1:0] op_i,
  input  logic            word_mode_i,
  input  logic            arith_i,
  input  logic [XLEN-1:0] data_i,
  input  logic [AMTW-1:0] amt_win_i,
  output shift_ctl_t      ctl_o,
  output logic [XLEN-1:0] src_o,
  output logic [AMTW-1:0] amt_o
);

  localparam int HALF = XLEN / 2;
  localparam int HAMT = AMTW - 1;

  logic is_shl, is_shr, is_sxw, sign_word, fill_bit;

  always_comb begin
    is_shl    = (op_i == SOP_SHL);
    is_shr    = (op_i == SOP_SHR);
    is_sxw    = (op_i == SOP_SXW_SHL);
    sign_word = data_i[HALF-1];
    fill_bit  = is_shr & arith_i & (word_mode_i ? sign_word : data_i[XLEN-1]);
  end

  always_comb begin
    ctl_o.valid     = is_shl | is_shr | is_sxw;
    ctl_o.dir_right = is_shr;
    ctl_o.word      = word_mode_i;
    ctl_o.fill      = fill_bit;

    src_o = '0;
    amt_o = '0;
    if (ctl_o.valid) begin
      if (word_mode_i) begin
        amt_o = {1'b0, amt_win_i[HAMT-1:0]};
      end else begin
        amt_o = amt_win_i;
      end

      if (is_shr) begin
        src_o = word_mode_i ? {{HALF{fill_bit}}, data_i[HALF-1:0]} : data_i;
      end else if (word_mode_i) begin
        src_o = {{HALF{1'b0}}, data_i[HALF-1:0]};
      end else if (is_sxw) begin
        src_o = {{HALF{sign_word}}, data_i[HALF-1:0]};
      end else begin
        src_o = data_i;
      end
    end
  end

  // R9: the 64-bit fused form presents a sign-extended word to the shifter
  always_comb begin
    if (is_sxw && !word_mode_i) begin
      a_r9_sext_source: assert (src_o[XLEN-1:HALF] == {HALF{data_i[HALF-1]}})
        else $error("sign-extended source upper half wrong");
    end
  end

endmodule

// File: rtl/shift_barrel.sv
module shift_barrel #(
  parameter int XLEN = 64,
  parameter int AMTW = $clog2(XLEN) + 1
) (
  input  logic            dir_right_i,
  input  logic            fill_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [AMTW-1:0] amt_i,
  output logic [XLEN-1:0] res_o
);

  localparam int STAGES = AMTW - 1;

  logic [XLEN-1:0] stage [STAGES+1];

  assign stage[0] = src_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [XLEN-1:0] moved;
    always_comb begin
      if (dir_right_i) begin
        moved = {{S{fill_i}}, stage[k][XLEN-1:S]};
      end else begin
        moved = {stage[k][XLEN-1-S:0], {S{1'b0}}};
      end
    end
    assign stage[k+1] = amt_i[k] ? moved : stage[k];
  end

  // The top amount bit means a full-width (or larger) shift.
  always_comb begin
    if (amt_i[AMTW-1]) begin
      res_o = {XLEN{fill_i}};
    end else begin
      res_o = stage[STAGES];
    end
  end

  // R2/R4/R5: an amount at or above the width leaves only fill bits
  always_comb begin
    if (amt_i[AMTW-1]) begin
      a_r5_full_fill: assert (res_o == {XLEN{fill_i}})
        else $error("oversize shift did not saturate to fill");
    end
  end

endmodule

// File: rtl/shift_merge.sv
module shift_merge
  import shift_unit_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  shift_ctl_t      ctl_i,
  input  logic [XLEN-1:0] raw_i,
  output logic [XLEN-1:0] res_o,
  output logic            valid_o
);

  localparam int HALF = XLEN / 2;

  logic [HALF-1:0] upper_word;

  always_comb begin
    upper_word = ctl_i.dir_right ? {HALF{ctl_i.fill}} : {HALF{1'b0}};
    valid_o    = ctl_i.valid;
    if (!ctl_i.valid) begin
      res_o = '0;
    end else if (ctl_i.word) begin
      res_o = {upper_word, raw_i[HALF-1:0]};
    end else begin
      res_o = raw_i;
    end
  end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_unit_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2:0]      op_i,
  input  logic            word_mode_i,
  input  logic            arith_i,
  input  logic [XLEN-1:0] data_i,
  input  logic [XLEN-1:0] amount_i,
  input  logic [XLEN-1:0] rot_i,
  output logic [XLEN-1:0] result_o,
  output logic            valid_o
);

  localparam int AMTW = $clog2(XLEN) + 1;
  localparam int HALF = XLEN / 2;

  shift_ctl_t      ctl;
  logic [XLEN-1:0] src;
  logic [AMTW-1:0] amt;
  logic [XLEN-1:0] raw;

  // Rotate source and high amount bits are never consumed (R10).
  logic unused_inputs;
  assign unused_inputs = ^{rot_i, amount_i[XLEN-1:AMTW]};

  shift_decode #(.XLEN(XLEN), .AMTW(AMTW)) u_decode (
    .op_i        (op_i),
    .word_mode_i (word_mode_i),
    .arith_i     (arith_i),
    .data_i      (data_i),
    .amt_win_i   (amount_i[AMTW-1:0]),
    .ctl_o       (ctl),
    .src_o       (src),
    .amt_o       (amt)
  );

  shift_barrel #(.XLEN(XLEN), .AMTW(AMTW)) u_barrel (
    .dir_right_i (ctl.dir_right),
    .fill_i      (ctl.fill),
    .src_i       (src),
    .amt_i       (amt),
    .res_o       (raw)
  );

  shift_merge #(.XLEN(XLEN)) u_merge (
    .ctl_i   (ctl),
    .raw_i   (raw),
    .res_o   (result_o),
    .valid_o (valid_o)
  );

  always_comb begin
    // R1: unsupported codes leave the result quiet
    if (!valid_o) begin
      a_r1_idle_zero: assert (result_o == '0)
        else $error("result not zero for unsupported code");
    end
    // R3/R8: word-mode left shifts clear the upper word
    if (valid_o && word_mode_i && op_i != SOP_SHR) begin
      a_r3_upper_clear: assert (result_o[XLEN-1:HALF] == '0)
        else $error("word left shift upper half not zero");
    end
    // R6: word-mode logical right shift clears the upper word
    if (op_i == SOP_SHR && word_mode_i && !arith_i) begin
      a_r6_upper_clear: assert (result_o[XLEN-1:HALF] == '0)
        else $error("word logical right shift upper half not zero");
    end
    // R7: word-mode arithmetic right shift replicates bit 31 upward
    if (op_i == SOP_SHR && word_mode_i && arith_i) begin
      a_r7_upper_sign: assert (result_o[XLEN-1:HALF] == {HALF{data_i[HALF-1]}})
        else $error("word arithmetic right shift upper half not sign");
    end
    // R2: 64-bit left shifts by 64 or more give zero
    if (op_i == SOP_SHL && !word_mode_i && amount_i[AMTW-1]) begin
      a_r2_big_zero: assert (result_o == '0)
        else $error("oversize left shift not zero");
    end
  end

endmodule

// File: tb/shift_unit_tb.sv
`timescale 1ns/1ps
module shift_unit_tb;

  logic        clk;
  logic [2:0]  op;
  logic        wm, ar;
  logic [63:0] da, am, ro;
  logic [63:0] res;
  logic        vld;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  shift_unit u_dut (
    .op_i(op), .word_mode_i(wm), .arith_i(ar), .data_i(da),
    .amount_i(am), .rot_i(ro), .result_o(res), .valid_o(vld)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic string tag_of(input logic [2:0] o, input logic w, input logic s);
    case (o)
      3'd1: return w ? "R3" : "R2";
      3'd2: return w ? (s ? "R7" : "R6") : (s ? "R5" : "R4");
      3'd3: return w ? "R8" : "R9";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [64:0] model(input logic [2:0] o, input logic w, input logic s,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [31:0]        lo;
    logic signed [31:0] s32;
    logic signed [63:0] s64;
    logic [63:0]        sx;
    s32 = a[31:0];
    s64 = a;
    sx  = {{32{a[31]}}, a[31:0]};
    case (o)
      3'd1, 3'd3: begin
        if (w) begin
          lo = a[31:0] << b[5:0];
          return {1'b1, 32'd0, lo};
        end
        if (o == 3'd1) return {1'b1, a << b[6:0]};
        return {1'b1, sx << b[6:0]};
      end
      3'd2: begin
        if (w) begin
          if (s) begin
            lo = s32 >>> b[5:0];
            return {1'b1, {32{a[31]}}, lo};
          end
          lo = a[31:0] >> b[5:0];
          return {1'b1, 32'd0, lo};
        end
        if (s) return {1'b1, 64'(s64 >>> b[6:0])};
        return {1'b1, a >> b[6:0]};
      end
      default: return 65'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [64:0] exp);
    n_run++;
    if ({vld, res} !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d w=%0d s=%0d a=%h b=%h: got v=%0d r=%h exp v=%0d r=%h",
               tag, op, wm, ar, da, am, vld, res, exp[64], exp[63:0]);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic w, input logic s,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] r);
    @(negedge clk);
    op = o; wm = w; ar = s; da = a; am = b; ro = r;
    #1;
    check(tag_of(o, w, s), model(o, w, s, a, b));
  endtask

  // R10: scramble everything the unit must ignore and expect no change
  task automatic apply_ignored(input logic [2:0] o, input logic w, input logic s,
                               input logic [63:0] a, input logic [63:0] b);
    logic [64:0] base;
    logic [63:0] b2;
    logic        s2;
    apply(o, w, s, a, b, 64'd0);
    base = {vld, res};
    b2 = {~b[63:7], (w ? ~b[6] : b[6]), b[5:0]};
    s2 = (o == 3'd2) ? s : ~s;
    @(negedge clk);
    op = o; wm = w; ar = s2; da = a; am = b2; ro = {$urandom, $urandom};
    #1;
    check("R10", base);
  endtask

  logic [63:0] dvals [10];
  logic [6:0]  avals [12];

  initial begin
    op = 0; wm = 0; ar = 0; da = 0; am = 0; ro = 0;
    @(negedge clk); #1;
    check("R1", 65'd0);  // idle state: code 0, all zero

    dvals[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    dvals[1] = 64'h0000_0000_FFFF_FFFF;
    dvals[2] = 64'h0000_0000_8000_0000;
    dvals[3] = 64'h8000_0000_0000_0001;
    dvals[4] = 64'h0000_0101_8012_2900;
    dvals[5] = 64'h8000_0000_FB40_13E2;
    dvals[6] = 64'h0000_0000_0000_0000;
    dvals[7] = 64'h7FFF_FFFF_7FFF_FFFF;
    dvals[8] = 64'h0000_0000_0000_0001;
    dvals[9] = 64'hFFFF_FFFF_0000_0000;
    avals[0] = 0;  avals[1] = 1;  avals[2] = 31; avals[3] = 32;
    avals[4] = 33; avals[5] = 63; avals[6] = 64; avals[7] = 65;
    avals[8] = 95; avals[9] = 96; avals[10] = 127; avals[11] = 7;

    for (int o = 0; o < 8; o++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 2; s++)
          for (int d = 0; d < 10; d++)
            for (int k = 0; k < 12; k++)
              apply(3'(o), 1'(w), 1'(s), dvals[d], {57'd0, avals[k]}, {$urandom, $urandom});

    for (int o = 1; o < 4; o++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 12; k++)
            apply_ignored(3'(o), 1'(w), 1'(s), {$urandom, $urandom},
                          {$urandom, 25'(0), avals[k]});

    for (int i = 0; i < 3000; i++)
      apply(3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule